// File: doc/BRIEF.md
# Scanline Position Timer Interrupt Controller

This block raises a host interrupt when the video beam reaches a programmed position on the screen. Software programs a 9-bit column and a 9-bit line compare value through a byte-wide register port, in separate low and high byte registers, and picks one of four trigger modes: off, column match on every line, line match at column zero, or column and line match together. The beam counters come in as inputs from the video timing logic. When the selected condition first becomes true, the block sets a sticky timer-up flag, captures the beam position into two latch outputs and drives the host interrupt.

The host interrupt line is the OR of the timer flag and an external cartridge interrupt input, so either source can interrupt the host without the two fighting over one line. Software acknowledges the timer by reading or writing the flag register, or by switching the trigger mode off. A read of the flag register carries the flag in bit 7 and the open-bus byte in the lower bits. A peek input lets a debugger read the flag register without clearing it.

All pins are plain control and status signals. The register port is a single-cycle strobe interface without back-pressure, so no valid/ready handshake is used.

Top module: `hv_timer_irq`

## Requirements
- R1: After reset the flag is 0, the trigger mode is off, both compare values are 0, both latch outputs are 0, and `host_irq` follows `cart_irq` alone.
- R2: Register addresses are 0 mode, 1 column low, 2 column high, 3 line low, 4 line high, 5 flag. A write to a high byte register keeps only data bit 0 as compare bit 8; a write to a low byte register replaces bits 7:0 and keeps the stored bit 8.
- R3: Mode is write data bits 5:4 of address 0. Mode 01 fires when the beam column equals the column compare, on any line. A match that stays true fires only once; the condition must go false and true again to fire again.
- R4: Mode 10 fires when the beam line equals the line compare while the beam column is 0.
- R5: Mode 11 fires only when the beam column and beam line both equal their compare values; mode 00 never fires.
- R6: The flag becomes 1 at the clock edge where the selected condition is first seen true on the inputs, and stays 1 until cleared.
- R7: At that same edge `latch_col` and `latch_line` capture the beam column and beam line.
- R8: While `reg_rd` is high with address 5, `reg_rdata` is the flag in bit 7 and `open_bus` bits 6:0 below it; reads of any other address return `open_bus`. A read with `peek` low clears the flag at the next edge.
- R9: Any write to address 5 clears the flag, whatever the data.
- R10: A write to address 0 with data bits 5:4 both 0 clears the flag, even if a trigger fires in the same cycle.
- R11: `host_irq` is 1 whenever the flag or `cart_irq` is 1, and 0 when both are 0.
- R12: A read of address 5 with `peek` high returns the same data and leaves the flag unchanged.
- R13: When a trigger fires in the same cycle as a read or write of address 5, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| peek | input | 1 | Read without side effects |
| open_bus | input | 8 | Floating bus value merged into reads |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high |
| beam_col | input | 9 | Current beam column |
| beam_line | input | 9 | Current beam line |
| cart_irq | input | 1 | External cartridge interrupt |
| host_irq | output | 1 | Merged interrupt to the host |
| latch_col | output | 9 | Beam column captured at the last trigger |
| latch_line | output | 9 | Beam line captured at the last trigger |

## Verification
The hardest situations to reach are a trigger landing in exactly the cycle that software acknowledges the flag, and a match that is held steady after acknowledgement and must not re-fire. The bench parks the beam on a non-matching position, then moves it onto the compare value in the same cycle as the flag register write, and separately clears the flag while the beam stays on the match, before stepping the column off and back on to prove the next trigger still arrives.

// File: rtl/hvt_pkg.sv
package hvt_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'b00,
    TRIG_COL  = 2'b01,
    TRIG_LINE = 2'b10,
    TRIG_BOTH = 2'b11
  } trig_mode_e;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MODE    = 3'd0;
  localparam logic [ADDR_W-1:0] A_COL_LO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_COL_HI  = 3'd2;
  localparam logic [ADDR_W-1:0] A_LINE_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_LINE_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAG    = 3'd5;

endpackage

// File: rtl/hvt_regs.sv
module hvt_regs
  import hvt_pkg::*;
#(
  parameter int unsigned POS_W  = 9,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MODE_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output trig_mode_e        mode,
  output logic [POS_W-1:0]  col_cmp,
  output logic [POS_W-1:0]  line_cmp,
  output logic              mode_off_wr
);

  localparam int unsigned HI_W = POS_W - DATA_W;

  logic wr_mode, wr_col_lo, wr_col_hi, wr_line_lo, wr_line_hi;

  assign wr_mode    = reg_wr && (reg_addr == A_MODE);
  assign wr_col_lo  = reg_wr && (reg_addr == A_COL_LO);
  assign wr_col_hi  = reg_wr && (reg_addr == A_COL_HI);
  assign wr_line_lo = reg_wr && (reg_addr == A_LINE_LO);
  assign wr_line_hi = reg_wr && (reg_addr == A_LINE_HI);

  assign mode_off_wr = wr_mode && (reg_wdata[MODE_LSB +: 2] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= TRIG_OFF;
      col_cmp  <= '0;
      line_cmp <= '0;
    end else begin
      if (wr_mode)    mode <= trig_mode_e'(reg_wdata[MODE_LSB +: 2]);
      if (wr_col_lo)  col_cmp[DATA_W-1:0]      <= reg_wdata;
      if (wr_col_hi)  col_cmp[POS_W-1:DATA_W]  <= reg_wdata[HI_W-1:0];
      if (wr_line_lo) line_cmp[DATA_W-1:0]     <= reg_wdata;
      if (wr_line_hi) line_cmp[POS_W-1:DATA_W] <= reg_wdata[HI_W-1:0];
    end
  end

  // R2: high byte write leaves low bits alone, low byte write leaves top bits alone
  p_hi_keeps_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_col_hi |=> col_cmp[DATA_W-1:0] == $past(col_cmp[DATA_W-1:0]));
  p_lo_keeps_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_line_lo |=> line_cmp[POS_W-1:DATA_W] == $past(line_cmp[POS_W-1:DATA_W]));

endmodule

// File: rtl/hvt_match.sv
module hvt_match
  import hvt_pkg::*;
#(
  parameter int unsigned POS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  trig_mode_e       mode,
  input  logic [POS_W-1:0] col_cmp,
  input  logic [POS_W-1:0] line_cmp,
  input  logic [POS_W-1:0] beam_col,
  input  logic [POS_W-1:0] beam_line,
  output logic             fire
);

  logic col_hit, line_hit, col_zero;
  logic cond, cond_q;

  assign col_hit  = (beam_col == col_cmp);
  assign line_hit = (beam_line == line_cmp);
  assign col_zero = (beam_col == '0);

  always_comb begin
    unique case (mode)
      TRIG_COL:  cond = col_hit;
      TRIG_LINE: cond = line_hit && col_zero;
      TRIG_BOTH: cond = col_hit && line_hit;
      default:   cond = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  assign fire = cond && !cond_q;

  // R3: a held match never produces two triggers back to back
  p_no_refire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  // R5: mode off never triggers
  p_off_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_OFF) |-> !fire);

endmodule

// File: rtl/hvt_flag.sv
module hvt_flag
  import hvt_pkg::*;
#(
  parameter int unsigned POS_W  = 9,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              mode_off_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              peek,
  input  logic [DATA_W-1:0] open_bus,
  input  logic [POS_W-1:0]  beam_col,
  input  logic [POS_W-1:0]  beam_line,
  output logic              flag,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [POS_W-1:0]  latch_col,
  output logic [POS_W-1:0]  latch_line
);

  logic flag_sel, ack;

  assign flag_sel = (reg_addr == A_FLAG);
  assign ack      = flag_sel && (reg_wr || (reg_rd && !peek));

  // Priority: mode-off write, then a new trigger, then acknowledge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag       <= 1'b0;
      latch_col  <= '0;
      latch_line <= '0;
    end else begin
      if (mode_off_wr)  flag <= 1'b0;
      else if (fire)    flag <= 1'b1;
      else if (ack)     flag <= 1'b0;
      if (fire) begin
        latch_col  <= beam_col;
        latch_line <= beam_line;
      end
    end
  end

  always_comb begin
    reg_rdata = open_bus;
    if (reg_rd && flag_sel) reg_rdata = {flag, open_bus[DATA_W-2:0]};
  end

  // R6 / R13: a trigger always leaves the flag set unless mode goes off
  p_fire_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !mode_off_wr) |=> flag);
  // R7: latch captures the beam position of the trigger cycle
  p_latch_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (latch_col == $past(beam_col)) && (latch_line == $past(beam_line)));
  // R8 / R9: acknowledge without a trigger clears
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !fire) |=> !flag);
  // R10: mode-off write always clears
  p_mode_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_off_wr |=> !flag);
  // R12: a peek read alone changes nothing
  p_peek_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && peek && !reg_wr && !fire && !mode_off_wr) |=> $stable(flag));

endmodule

// File: rtl/hv_timer_irq.sv
module hv_timer_irq
  import hvt_pkg::*;
#(
  parameter int unsigned POS_W  = 9,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  input  logic              peek,
  input  logic [DATA_W-1:0] open_bus,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [POS_W-1:0]  beam_col,
  input  logic [POS_W-1:0]  beam_line,
  input  logic              cart_irq,
  output logic              host_irq,
  output logic [POS_W-1:0]  latch_col,
  output logic [POS_W-1:0]  latch_line
);

  trig_mode_e       mode;
  logic [POS_W-1:0] col_cmp, line_cmp;
  logic             mode_off_wr, fire, flag;

  hvt_regs #(.POS_W(POS_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .mode(mode), .col_cmp(col_cmp),
    .line_cmp(line_cmp), .mode_off_wr(mode_off_wr)
  );

  hvt_match #(.POS_W(POS_W)) u_match (
    .clk(clk), .rst_n(rst_n), .mode(mode), .col_cmp(col_cmp),
    .line_cmp(line_cmp), .beam_col(beam_col), .beam_line(beam_line),
    .fire(fire)
  );

  hvt_flag #(.POS_W(POS_W), .DATA_W(DATA_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .fire(fire), .mode_off_wr(mode_off_wr),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .peek(peek),
    .open_bus(open_bus), .beam_col(beam_col), .beam_line(beam_line),
    .flag(flag), .reg_rdata(reg_rdata), .latch_col(latch_col),
    .latch_line(latch_line)
  );

  assign host_irq = flag | cart_irq;

  // R11: the cartridge request always reaches the host
  p_cart_passes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cart_irq |-> host_irq);
  // R11: a raised host line has a source
  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (cart_irq || reg_rdata[DATA_W-1] || !reg_rd || reg_addr != A_FLAG));

endmodule

// File: tb/hv_timer_irq_tb.sv
module hv_timer_irq_tb;
  import hvt_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, peek = 1'b0;
  logic [7:0] reg_wdata = '0, open_bus = 8'h5A;
  logic [7:0] reg_rdata;
  logic [8:0] beam_col = 9'd300, beam_line = 9'd300;
  logic       cart_irq = 1'b0, host_irq;
  logic [8:0] latch_col, latch_line;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  hv_timer_irq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .peek(peek), .open_bus(open_bus),
    .reg_rdata(reg_rdata), .beam_col(beam_col), .beam_line(beam_line),
    .cart_irq(cart_irq), .host_irq(host_irq), .latch_col(latch_col),
    .latch_line(latch_line)
  );

  // {mode[1:0], col_cmp[8:0], line_cmp[8:0], beam_col[8:0], beam_line[8:0], fire}
  localparam int NV = 10;
  localparam logic [38:0] VEC [NV] = '{
    {2'b01, 9'h010, 9'h000, 9'h010, 9'h007, 1'b1},
    {2'b01, 9'h010, 9'h000, 9'h011, 9'h007, 1'b0},
    {2'b01, 9'h105, 9'h000, 9'h105, 9'h000, 1'b1},
    {2'b01, 9'h105, 9'h000, 9'h005, 9'h000, 1'b0},
    {2'b10, 9'h000, 9'h020, 9'h000, 9'h020, 1'b1},
    {2'b10, 9'h000, 9'h020, 9'h003, 9'h020, 1'b0},
    {2'b11, 9'h040, 9'h050, 9'h040, 9'h050, 1'b1},
    {2'b11, 9'h040, 9'h050, 9'h040, 9'h051, 1'b0},
    {2'b00, 9'h040, 9'h050, 9'h040, 9'h050, 1'b0},
    {2'b10, 9'h000, 9'h1A0, 9'h000, 9'h1A0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic peek_flag();
    return reg_rdata[7];
  endfunction

  task automatic peek_read(output logic [7:0] d);
    reg_addr = A_FLAG; reg_rd = 1'b1; peek = 1'b1;
    #1 d = reg_rdata;
    reg_rd = 1'b0; peek = 1'b0;
  endtask

  task automatic setup(input logic [1:0] m, input logic [8:0] c, input logic [8:0] l);
    beam_col = 9'd300; beam_line = 9'd300;
    wr(A_MODE, {2'b11, m, 4'hF});
    wr(A_COL_HI, {7'h7F, c[8]});
    wr(A_COL_LO, c[7:0]);
    wr(A_LINE_HI, {7'h7F, l[8]});
    wr(A_LINE_LO, l[7:0]);
    wr(A_FLAG, 8'h00);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek_read(d);
    chk("R1 flag", d[7], 1'b0);
    chk("R1 host_irq", host_irq, 1'b0);
    chk("R1 latch", {latch_col, latch_line}, 18'h0);
    beam_col = 9'd0; beam_line = 9'd0;   // compares are 0 but mode is off
    @(negedge clk); @(negedge clk);
    peek_read(d);
    chk("R1 mode off after reset", d[7], 1'b0);

    // R2..R7 vector walk
    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      setup(v[38:37], v[36:28], v[27:19]);
      @(negedge clk);
      beam_col = v[18:10]; beam_line = v[9:1];
      @(negedge clk);
      peek_read(d);
      chk($sformatf("R2-vec%0d R3 R4 R5 R6 flag", i), d[7], v[0]);
      chk($sformatf("R11 vec%0d host_irq", i), host_irq, v[0]);
      if (v[0]) chk($sformatf("R7 vec%0d latch", i), {latch_col, latch_line}, {v[18:10], v[9:1]});
    end

    // R8: read data and clearing read; flag currently set from last vector
    reg_addr = A_FLAG; reg_rd = 1'b1; peek = 1'b1; open_bus = 8'h33;
    #1 chk("R8 rdata format", reg_rdata, 8'hB3);
    reg_addr = A_COL_LO;
    #1 chk("R8 other addr open bus", reg_rdata, 8'h33);
    reg_rd = 1'b0; peek = 1'b0;
    // R12: peek over an edge keeps flag
    reg_addr = A_FLAG; reg_rd = 1'b1; peek = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; peek = 1'b0;
    peek_read(d);
    chk("R12 peek keeps flag", d[7], 1'b1);
    reg_addr = A_FLAG; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    peek_read(d);
    chk("R8 read clears flag", d[7], 1'b0);

    // R3 held match does not refire; off-and-on fires again
    setup(2'b01, 9'h010, 9'h000);
    @(negedge clk);
    beam_col = 9'h010;
    @(negedge clk);
    wr(A_FLAG, 8'hFF);                 // R9 clear with all-ones data
    peek_read(d);
    chk("R9 write clears flag", d[7], 1'b0);
    repeat (3) @(negedge clk);
    peek_read(d);
    chk("R3 held match no refire", d[7], 1'b0);
    beam_col = 9'h011;
    @(negedge clk);
    beam_col = 9'h010;
    @(negedge clk);
    peek_read(d);
    chk("R3 next line fires again", d[7], 1'b1);

    // R10 mode-off write clears flag
    wr(A_MODE, 8'hCF);
    peek_read(d);
    chk("R10 mode off clears", d[7], 1'b0);
    chk("R10 host_irq dropped", host_irq, 1'b0);

    // R13 trigger coinciding with flag write
    setup(2'b01, 9'h020, 9'h000);
    @(negedge clk);
    beam_col = 9'h020; reg_addr = A_FLAG; reg_wdata = 8'h00; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    peek_read(d);
    chk("R13 set wins over write", d[7], 1'b1);

    // R11 cartridge interrupt merge
    wr(A_MODE, 8'h00);
    cart_irq = 1'b1;
    #1 chk("R11 cart alone raises irq", host_irq, 1'b1);
    cart_irq = 1'b0;
    #1 chk("R11 both low irq low", host_irq, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule